// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block tracks whether a processor core is halted in debug mode. Exception causes arrive on a 32-bit input each clock. Breakpoint and watchpoint requests also arrive on their own inputs. Every cause is latched into a sticky cause register. A per-cause enable register decides which latched causes halt the core. When any latched cause is also enabled, the block asserts a freeze output. On that entry it saves the current program counter and machine state. While frozen, it forces the external interrupt enable bit of the machine state to zero.

A debug host has a small register port. It writes the enable register, and it reads the cause register; the read clears the register. A return-from-interrupt strobe leaves debug mode and restores the saved machine state for one cycle. If an enabled cause is still latched at that point, debug mode is entered again at once. The instruction pipeline and the serial link to the host lie outside this block.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, `freeze` is 0, `cause_any` is 0, and the cause and enable registers are all zero.
- R2: Any bit set on `cause_in` in a cycle is set in the cause register from the next cycle and stays set. `cause_any` is 1 whenever any cause bit is set.
- R3: `host_rdata` shows the cause register. A cycle with `host_rd` high clears every bit at the next edge, except bits that arrive in that same cycle, which stay set.
- R4: `host_wr` loads `host_wdata` into the enable register. In normal mode, `freeze` rises at the edge after the first cycle on which the cause register AND the enable register is non-zero.
- R5: `saved_pc` and `saved_msr` take `pc_in` and `msr_in` only at the edge where `freeze` rises. They hold while `freeze` stays high.
- R6: While `freeze` is high, `ee_force_clr` is 1 and `msr_out` equals `msr_in` with bit 15 (external interrupt enable) forced to 0.
- R7: A breakpoint request sets cause bit 30 and a watchpoint request sets cause bit 31. Both are ignored while `freeze` is high.
- R8: A `rfi` pulse in debug mode drops `freeze` at the next edge. A `rfi` pulse in normal mode has no effect.
- R9: If an enabled cause bit is still set when `rfi` exits, `freeze` rises again one cycle later.
- R10: For the single cycle after an exit by `rfi`, `msr_out` equals `saved_msr`, including bit 15. After that cycle it follows `msr_in`.
- R11: A cause held high as a level is recorded again on every cycle, so a host read during the level does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_in | input | 32 | Exception cause bits, level or pulse |
| bkpt_req | input | 1 | Breakpoint request |
| wtpt_req | input | 1 | Watchpoint request |
| rfi | input | 1 | Return-from-interrupt strobe |
| pc_in | input | 32 | Current program counter |
| msr_in | input | 32 | Current machine state |
| host_rd | input | 1 | Host read of the cause register (clears it) |
| host_wr | input | 1 | Host write of the enable register |
| host_wdata | input | 32 | Enable register write data |
| host_rdata | output | 32 | Cause register contents |
| freeze | output | 1 | Debug mode indication |
| cause_any | output | 1 | OR of all latched cause bits |
| saved_pc | output | 32 | Program counter saved on entry |
| saved_msr | output | 32 | Machine state saved on entry |
| msr_out | output | 32 | Machine state presented to the core |
| ee_force_clr | output | 1 | Forces the external interrupt enable bit low |

## Verification
The assertions assume `rfi` is a single-cycle pulse and that the reset input is synchronous and driven cleanly. They also assume that causes may arrive in any cycle, including cycles with a host read or a `rfi` pulse. The properties are therefore written only about state that the block itself owns. The bench drives every input on the falling clock edge and keeps `rfi` to one-cycle pulses. It holds `pc_in` and `msr_in` steady around each expected entry edge, so the values captured at that edge are known exactly.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int DBG_XLEN     = 32;
    localparam int DBG_EE_BIT   = 15;
    localparam int DBG_BKPT_BIT = 30;
    localparam int DBG_WTPT_BIT = 31;

    typedef struct packed {
        logic freeze;
        logic restore;
    } mode_t;
endpackage

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg
    import dbg_pkg::*;
#(
    parameter int W        = DBG_XLEN,
    parameter int BKPT_BIT = DBG_BKPT_BIT,
    parameter int WTPT_BIT = DBG_WTPT_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_in,
    input  logic         bkpt_req,
    input  logic         wtpt_req,
    input  logic         freeze_i,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] cause_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] en;
    } creg_t;

    creg_t        st_d, st_q;
    logic [W-1:0] new_bits;

    always_comb begin
        new_bits = cause_in;
        if (!freeze_i) begin
            new_bits[BKPT_BIT] = cause_in[BKPT_BIT] | bkpt_req;
            new_bits[WTPT_BIT] = cause_in[WTPT_BIT] | wtpt_req;
        end
        st_d       = st_q;
        st_d.cause = (host_rd ? '0 : st_q.cause) | new_bits;
        if (host_wr) st_d.en = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign hit_o   = |(st_q.cause & st_q.en);

    // R2: every arriving cause bit appears in the register
    a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (new_bits != '0) |=> ((st_q.cause & $past(new_bits)) == $past(new_bits)));
    // R3: read with nothing arriving empties the register
    a_r3_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && new_bits == '0) |=> (st_q.cause == '0));
    // R7: breakpoint request ignored in debug mode
    a_r7_bkpt_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && host_rd && !cause_in[BKPT_BIT]) |=> !st_q.cause[BKPT_BIT]);
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_pkg::*;
#(
    parameter int W = DBG_XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit_i,
    input  logic         rfi,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] msr_in,
    output logic         freeze_o,
    output logic         restore_o,
    output logic [W-1:0] saved_pc_o,
    output logic [W-1:0] saved_msr_o
);
    mode_t        md_d, md_q;
    logic [W-1:0] spc_d, spc_q, smsr_d, smsr_q;

    always_comb begin
        md_d         = md_q;
        spc_d        = spc_q;
        smsr_d       = smsr_q;
        md_d.restore = 1'b0;
        if (md_q.freeze) begin
            if (rfi) begin
                md_d.freeze  = 1'b0;
                md_d.restore = 1'b1;
            end
        end else if (hit_i) begin
            md_d.freeze = 1'b1;
            spc_d       = pc_in;
            smsr_d      = msr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q   <= '0;
            spc_q  <= '0;
            smsr_q <= '0;
        end else begin
            md_q   <= md_d;
            spc_q  <= spc_d;
            smsr_q <= smsr_d;
        end
    end

    assign freeze_o    = md_q.freeze;
    assign restore_o   = md_q.restore;
    assign saved_pc_o  = spc_q;
    assign saved_msr_o = smsr_q;

    // R4: enabled cause in normal mode enters debug mode
    a_r4_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!md_q.freeze && hit_i) |=> md_q.freeze);
    // R8: rfi in debug mode leaves it
    a_r8_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q.freeze && rfi) |=> !md_q.freeze);
    // R5: saved registers hold while frozen
    a_r5_saved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (md_q.freeze && $past(md_q.freeze)) |-> ($stable(spc_q) && $stable(smsr_q)));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_pkg::*;
#(
    parameter int W        = DBG_XLEN,
    parameter int EE_BIT   = DBG_EE_BIT,
    parameter int BKPT_BIT = DBG_BKPT_BIT,
    parameter int WTPT_BIT = DBG_WTPT_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_in,
    input  logic         bkpt_req,
    input  logic         wtpt_req,
    input  logic         rfi,
    input  logic [W-1:0] pc_in,
    input  logic [W-1:0] msr_in,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    output logic         freeze,
    output logic         cause_any,
    output logic [W-1:0] saved_pc,
    output logic [W-1:0] saved_msr,
    output logic [W-1:0] msr_out,
    output logic         ee_force_clr
);
    logic         hit, restore;
    logic [W-1:0] cause;

    dbg_cause_reg #(.W(W), .BKPT_BIT(BKPT_BIT), .WTPT_BIT(WTPT_BIT)) u_cause (
        .clk(clk), .rst_n(rst_n), .cause_in(cause_in), .bkpt_req(bkpt_req),
        .wtpt_req(wtpt_req), .freeze_i(freeze), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .cause_o(cause), .hit_o(hit)
    );

    dbg_mode_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .rfi(rfi), .pc_in(pc_in),
        .msr_in(msr_in), .freeze_o(freeze), .restore_o(restore),
        .saved_pc_o(saved_pc), .saved_msr_o(saved_msr)
    );

    always_comb begin
        msr_out = msr_in;
        if (freeze)       msr_out[EE_BIT] = 1'b0;
        else if (restore) msr_out = saved_msr;
    end

    assign host_rdata   = cause;
    assign cause_any    = |cause;
    assign ee_force_clr = freeze;

    // R6: interrupt enable held low throughout debug mode
    a_r6_ee_low: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (!msr_out[EE_BIT] && ee_force_clr));
endmodule

// File: tb/dbg_mode_ctrl_tb.sv
module dbg_mode_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cause_in = '0, pc_in = '0, msr_in = '0, host_wdata = '0;
    logic        bkpt_req = 1'b0, wtpt_req = 1'b0, rfi = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_rdata, saved_pc, saved_msr, msr_out;
    logic        freeze, cause_any, ee_force_clr;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    dbg_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cause_in(cause_in), .bkpt_req(bkpt_req),
        .wtpt_req(wtpt_req), .rfi(rfi), .pc_in(pc_in), .msr_in(msr_in),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .freeze(freeze), .cause_any(cause_any),
        .saved_pc(saved_pc), .saved_msr(saved_msr), .msr_out(msr_out),
        .ee_force_clr(ee_force_clr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic clear_causes();
        host_rd = 1'b1; nxt(); host_rd = 1'b0; nxt();
    endtask

    task automatic t_reset();
        chk("R1 freeze", {31'b0, freeze}, 32'd0);
        chk("R1 cause_any", {31'b0, cause_any}, 32'd0);
        chk("R1 cause", host_rdata, 32'd0);
        cause_in = 32'h8; nxt(); cause_in = '0; nxt();
        chk("R1 enable zero, no entry", {31'b0, freeze}, 32'd0);
        clear_causes();
    endtask

    task automatic t_latch_read();
        cause_in = 32'h5; nxt(); cause_in = '0;
        chk("R2 latched", host_rdata, 32'h5);
        chk("R2 cause_any", {31'b0, cause_any}, 32'd1);
        nxt();
        chk("R2 sticky", host_rdata, 32'h5);
        host_rd = 1'b1; cause_in = 32'h100; nxt();
        host_rd = 1'b0; cause_in = '0;
        chk("R3 read clears, new cause stays", host_rdata, 32'h100);
        clear_causes();
        chk("R3 cleared", host_rdata, 32'h0);
        chk("R3 cause_any low", {31'b0, cause_any}, 32'd0);
    endtask

    task automatic t_enter();
        host_wr = 1'b1; host_wdata = 32'h8; nxt(); host_wr = 1'b0;
        pc_in = 32'h1000; msr_in = 32'h8002;
        bkpt_req = 1'b1; nxt(); bkpt_req = 1'b0;
        chk("R7 bkpt in normal mode", host_rdata, 32'h4000_0000);
        clear_causes();
        cause_in = 32'h8; nxt(); cause_in = '0;
        chk("R4 not yet frozen", {31'b0, freeze}, 32'd0);
        nxt();
        chk("R4 frozen", {31'b0, freeze}, 32'd1);
        chk("R5 saved pc", saved_pc, 32'h1000);
        chk("R5 saved msr", saved_msr, 32'h8002);
        chk("R6 msr_out EE low", msr_out, 32'h0002);
        chk("R6 ee_force_clr", {31'b0, ee_force_clr}, 32'd1);
        pc_in = 32'h2000; msr_in = 32'h8004;
        cause_in = 32'h10; nxt(); cause_in = '0; nxt();
        chk("R5 saved pc holds", saved_pc, 32'h1000);
        chk("R5 saved msr holds", saved_msr, 32'h8002);
        chk("R2 cause recorded in debug", host_rdata, 32'h18);
        bkpt_req = 1'b1; wtpt_req = 1'b1; host_rd = 1'b1; nxt();
        bkpt_req = 1'b0; wtpt_req = 1'b0; host_rd = 1'b0;
        chk("R7 bkpt/wtpt ignored in debug", host_rdata, 32'h0);
    endtask

    task automatic t_exit();
        msr_in = 32'h0;
        rfi = 1'b1; nxt(); rfi = 1'b0;
        chk("R8 exit", {31'b0, freeze}, 32'd0);
        chk("R10 msr restored", msr_out, 32'h8002);
        nxt();
        chk("R10 restore one cycle", msr_out, 32'h0);
        chk("R8 stays out", {31'b0, freeze}, 32'd0);
        rfi = 1'b1; nxt(); rfi = 1'b0;
        chk("R8 rfi ignored in normal", {31'b0, freeze}, 32'd0);
        chk("R8 no restore from idle rfi", msr_out, 32'h0);
    endtask

    task automatic t_reenter();
        pc_in = 32'h3000; msr_in = 32'h8010;
        cause_in = 32'h8; nxt(); cause_in = '0; nxt();
        chk("R4 frozen again", {31'b0, freeze}, 32'd1);
        chk("R5 recaptured pc", saved_pc, 32'h3000);
        pc_in = 32'h4000;
        rfi = 1'b1; nxt(); rfi = 1'b0;
        chk("R9 exit first", {31'b0, freeze}, 32'd0);
        nxt();
        chk("R9 re-entered", {31'b0, freeze}, 32'd1);
        chk("R5 pc on re-entry", saved_pc, 32'h4000);
    endtask

    task automatic t_level();
        cause_in = 32'h4; nxt();
        chk("R11 level latched", host_rdata, 32'h0000_000c);
        host_rd = 1'b1; nxt(); host_rd = 1'b0;
        chk("R11 level survives read", host_rdata, 32'h4);
        nxt();
        chk("R11 level held", host_rdata, 32'h4);
        cause_in = '0; clear_causes();
        chk("R11 gone after release", host_rdata, 32'h0);
        rfi = 1'b1; nxt(); rfi = 1'b0; nxt();
        chk("R9 no re-entry when clear", {31'b0, freeze}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) nxt();
        rst_n = 1'b1;
        nxt();
        t_reset();
        t_latch_read();
        t_enter();
        t_exit();
        t_reenter();
        t_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule